// File: doc/BRIEF.md
# Timer DMA Burst Window

This block lets a DMA engine reach a run of timer registers through one fixed window address. When an internal timer event arrives and its request-enable bit is set, the block starts a burst. It raises a DMA request and waits for the engine to access the window. It then moves to the next word and requests again, until the programmed number of transfers is done. Each window access is steered to an internal register. That register is chosen by a configured start offset plus four bytes for each transfer already completed in the burst.

The same register bus serves the CPU and the DMA. The DMA marks its window accesses with an acknowledge strobe. A CPU access to the window that carries no acknowledge always lands on the start offset. The block also contains a 32-word internal register bank and a free-running counter. The counter stops while a debug halt is asserted and the hold bit is set.

Top module: `tmr_dma_burst`

## Requirements
- R1: A synchronous active-high reset leaves `dma_req` low, the configuration register, every bank word and the counter at zero.
- R2: A pulse on `evt_in[i]` starts a burst only when `evt_req_en[i]` is 1. In that case `dma_req` is high in the cycle after the event is sampled. A pulse with its enable at 0 leaves `dma_req` low.
- R3: With count field value N, one event produces exactly N+1 accepted requests. N=0 gives one request and N=3 gives four. `dma_req` then stays low.
- R4: The k-th accepted access of a burst (k from 0) reads or writes the register at byte offset start+4*k. Bank word j sits at byte offset 4*j, and offsets 0x00..0x7C form the bank.
- R5: An access is accepted when `bus_valid`, an address of 0x84 (the window) and `dma_ack` are high while `dma_req` is high. `dma_req` is low in the cycle after acceptance and high again one cycle later if transfers remain, so at most one request is outstanding.
- R6: An event that arrives while a burst is running is ignored. It does not lengthen or restart the burst.
- R7: An enabled event after a burst has finished starts a new burst from the configured start offset, with the index back at 0.
- R8: A window access without `dma_ack`, or any window access while no request is pending, targets the start offset and does not advance the burst index.
- R9: A computed offset of 0x80 or above reads as zero, and a write to it changes no register. This includes the configuration register.
- R10: The counter on `cnt_val` and at address 0x88 increments once per cycle. It holds its value while `dbg_halt` is 1 and the hold bit is 1. A halt with the hold bit at 0 has no effect.
- R11: The configuration register at 0x80 reads back as written, with the start offset in bits [7:0], the count field in bits [12:8] and the hold bit in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access strobe for the current cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| dma_ack | input | 1 | Marks a window access as the DMA answer to the pending request |
| dma_req | output | 1 | DMA request |
| evt_in | input | 4 | Internal timer event pulses |
| evt_req_en | input | 4 | Per-event request enable |
| dbg_halt | input | 1 | Debug halt indication |
| cnt_val | output | 16 | Counter value |

## Verification
Read data is combinational, so the scoreboard compares each read at the falling edge inside the access cycle. Writes and configuration changes take effect at the next rising edge, and the checks only use them after that edge. A sampled event shows up on `dma_req` at the falling edge after the edge that captured it. After an accepted access, the request is checked low at the next falling edge and high again one falling edge later. Counter checks compare values taken at consecutive falling edges, so the expected difference is exactly 1 or exactly 0.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } burst_st_e;
endpackage

// File: rtl/tdb_burst_ctrl.sv
module tdb_burst_ctrl
    import tdb_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             acc,
    input  logic [OFF_W-1:0] cfg_start,
    input  logic [IDX_W-1:0] cfg_count,
    output logic             req,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] last,
    output logic [OFF_W-1:0] start_lat,
    output burst_st_e        st
);
    typedef struct packed {
        burst_st_e        st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic [OFF_W-1:0] start;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (fire) begin
                    ctl_d.st    = ST_REQ;
                    ctl_d.idx   = '0;
                    ctl_d.last  = cfg_count;
                    ctl_d.start = cfg_start;
                end
            end
            ST_REQ: begin
                if (acc) begin
                    if (ctl_q.idx == ctl_q.last) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.idx = '0;
                    end else begin
                        ctl_d.st  = ST_GAP;
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            ST_GAP:  ctl_d.st = ST_REQ;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: ST_IDLE, idx: '0, last: '0, start: '0};
        else     ctl_q <= ctl_d;
    end

    assign req       = (ctl_q.st == ST_REQ);
    assign busy      = (ctl_q.st != ST_IDLE);
    assign idx       = ctl_q.idx;
    assign last      = ctl_q.last;
    assign start_lat = ctl_q.start;
    assign st        = ctl_q.st;
endmodule

// File: rtl/tdb_addr_map.sv
module tdb_addr_map #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 5,
    parameter int NREG   = 32
) (
    input  logic                    win_hit,
    input  logic                    use_burst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [ADDR_W-1:0]       start_burst,
    input  logic [ADDR_W-1:0]       start_cfg,
    input  logic [IDX_W-1:0]        idx,
    output logic [$clog2(NREG)-1:0] tgt_word,
    output logic                    tgt_in_bank
);
    localparam int WORD_W     = $clog2(NREG);
    localparam int BASE_W     = (ADDR_W > IDX_W + 2) ? ADDR_W : IDX_W + 2;
    localparam int SUM_W      = BASE_W + 1;
    localparam int BANK_BYTES = NREG * 4;

    logic [SUM_W-1:0] off;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] step;

    always_comb begin
        base = use_burst ? SUM_W'(start_burst) : SUM_W'(start_cfg);
        step = use_burst ? SUM_W'({idx, 2'b00}) : '0;
        off  = win_hit ? (base + step) : SUM_W'(bus_addr);
    end

    assign tgt_in_bank = (off < SUM_W'(BANK_BYTES));
    assign tgt_word    = off[WORD_W+1:2];
endmodule

// File: rtl/tdb_reg_bank.sv
module tdb_reg_bank #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [$clog2(NREG)-1:0] rd_word,
    output logic [DATA_W-1:0]       rd_data
);
    logic [DATA_W-1:0] mem_d [NREG];
    logic [DATA_W-1:0] mem_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[wr_word] = wr_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) mem_q[i] <= '0;
            else     mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_word];
endmodule

// File: rtl/tdb_counter.sv
module tdb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!freeze) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_dma_burst.sv
module tmr_dma_burst
    import tdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NREG   = 32,
    parameter int NEVT   = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_ack,
    output logic              dma_req,
    input  logic [NEVT-1:0]   evt_in,
    input  logic [NEVT-1:0]   evt_req_en,
    input  logic              dbg_halt,
    output logic [CNT_W-1:0]  cnt_val
);
    localparam int IDX_W      = $clog2(NREG);
    localparam int BANK_BYTES = NREG * 4;
    localparam int HOLD_BIT   = DATA_W - 1;
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(BANK_BYTES);
    localparam logic [ADDR_W-1:0] WIN_ADDR = ADDR_W'(BANK_BYTES + 4);
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(BANK_BYTES + 8);

    typedef struct packed {
        logic              hold;
        logic [IDX_W-1:0]  count;
        logic [ADDR_W-1:0] start;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    logic              win_hit, cfg_hit, cnt_hit, bank_hit;
    logic              fire, acc, busy, req;
    logic [IDX_W-1:0]  idx, last;
    logic [ADDR_W-1:0] start_lat;
    burst_st_e         st;
    logic [IDX_W-1:0]  tgt_word;
    logic              tgt_in_bank;
    logic [DATA_W-1:0] bank_rd;
    logic              bank_we;

    assign win_hit  = bus_valid && (bus_addr == WIN_ADDR);
    assign cfg_hit  = bus_valid && (bus_addr == CFG_ADDR);
    assign cnt_hit  = bus_valid && (bus_addr == CNT_ADDR);
    assign bank_hit = bus_valid && (bus_addr < CFG_ADDR);
    assign fire     = |(evt_in & evt_req_en);
    assign acc      = win_hit && dma_ack && req;

    tdb_burst_ctrl #(.IDX_W(IDX_W), .OFF_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .acc       (acc),
        .cfg_start (cfg_q.start),
        .cfg_count (cfg_q.count),
        .req       (req),
        .busy      (busy),
        .idx       (idx),
        .last      (last),
        .start_lat (start_lat),
        .st        (st)
    );

    tdb_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NREG(NREG)) u_map (
        .win_hit     (win_hit),
        .use_burst   (acc),
        .bus_addr    (bus_addr),
        .start_burst (start_lat),
        .start_cfg   (cfg_q.start),
        .idx         (idx),
        .tgt_word    (tgt_word),
        .tgt_in_bank (tgt_in_bank)
    );

    assign bank_we = bus_write && (win_hit || bank_hit) && tgt_in_bank;

    tdb_reg_bank #(.NREG(NREG), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bank_we),
        .wr_word (tgt_word),
        .wr_data (bus_wdata),
        .rd_word (tgt_word),
        .rd_data (bank_rd)
    );

    tdb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .freeze (dbg_halt && cfg_q.hold),
        .cnt    (cnt_val)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_hit && bus_write) begin
            cfg_d.start = bus_wdata[ADDR_W-1:0];
            cfg_d.count = bus_wdata[ADDR_W+IDX_W-1:ADDR_W];
            cfg_d.hold  = bus_wdata[HOLD_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (win_hit || bank_hit) begin
            if (tgt_in_bank) bus_rdata = bank_rd;
        end else if (cfg_hit) begin
            bus_rdata[ADDR_W-1:0]            = cfg_q.start;
            bus_rdata[ADDR_W+IDX_W-1:ADDR_W] = cfg_q.count;
            bus_rdata[HOLD_BIT]              = cfg_q.hold;
        end else if (cnt_hit) begin
            bus_rdata[CNT_W-1:0] = cnt_val;
        end
    end

    assign dma_req = req;
endmodule

module tdb_checker
    import tdb_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int NEVT  = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             dma_req,
    input logic             acc,
    input logic             busy,
    input logic [NEVT-1:0]  evt_in,
    input logic [NEVT-1:0]  evt_req_en,
    input logic [IDX_W-1:0] idx,
    input logic [IDX_W-1:0] last,
    input logic             dbg_halt,
    input logic             hold,
    input logic [CNT_W-1:0] cnt_val,
    input burst_st_e        st
);
    p_req_enable_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(|(evt_in & evt_req_en))) |=> !dma_req);

    p_one_outstanding_r5: assert property (@(posedge clk) disable iff (rst)
        acc |=> !dma_req);

    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= last));

    p_busy_ignores_evt_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !acc) |=> ($stable(last) && busy));

    p_cnt_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt && hold) |=> $stable(cnt_val));

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
        !(dbg_halt && hold) |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

    p_state_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |=> (st == ST_REQ));
endmodule

bind tmr_dma_burst tdb_checker #(.IDX_W(IDX_W), .NEVT(NEVT), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dma_req    (dma_req),
    .acc        (acc),
    .busy       (busy),
    .evt_in     (evt_in),
    .evt_req_en (evt_req_en),
    .idx        (idx),
    .last       (last),
    .dbg_halt   (dbg_halt),
    .hold       (cfg_q.hold),
    .cnt_val    (cnt_val),
    .st         (st)
);

// File: tb/tmr_dma_burst_bench.sv
module tmr_dma_burst_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CFG = 8'h80;
    localparam logic [7:0] A_WIN = 8'h84;
    localparam logic [7:0] A_CNT = 8'h88;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0, dma_ack = 1'b0, dbg_halt = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dma_req;
    logic [3:0]  evt_in = '0, evt_req_en = '0;
    logic [15:0] cnt_val;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t rdq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_dma_burst u_tmr_dma_burst (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_ack(dma_ack), .dma_req(dma_req), .evt_in(evt_in),
        .evt_req_en(evt_req_en), .dbg_halt(dbg_halt), .cnt_val(cnt_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares every read in its access cycle
    always @(negedge clk) begin
        if (bus_valid && !bus_write) begin
            if (rdq.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard actual=%h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = rdq.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                          input logic ack, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d; dma_ack = ack;
        if (!w) rdq.push_back('{exp: exp, tag: tag});
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0; dma_ack = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        access(1'b1, a, d, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        access(1'b0, a, '0, 1'b0, exp, tag);
    endtask

    task automatic pulse(input logic [3:0] e);
        @(posedge clk); #1; evt_in = e;
        @(posedge clk); #1; evt_in = '0;
    endtask

    // one DMA transfer answering the pending request, then request timing checks
    task automatic dma_xfer(input logic w, input logic [31:0] d, input logic [31:0] exp,
                            input bit more, input string tag);
        @(negedge clk);
        chk({tag, " R5 req pending"}, {31'b0, dma_req}, 32'd1);
        access(w, A_WIN, d, 1'b1, exp, tag);
        @(negedge clk);
        chk("R5 req low after ack", {31'b0, dma_req}, 32'd0);
        if (more) begin
            @(negedge clk);
            chk("R5 req back", {31'b0, dma_req}, 32'd1);
        end
    endtask

    task automatic req_quiet(input string tag);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tag, {31'b0, dma_req}, 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] c0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 req at reset", {31'b0, dma_req}, 32'd0);
        chk("R1 counter at reset", {16'b0, cnt_val}, 32'd0);
        @(posedge clk); #1; rst = 1'b0;
        rd(A_CFG, 32'h0, "R1 cfg zero");
        rd(8'h14, 32'h0, "R1 bank zero");

        // R11 config readback
        wr(A_CFG, 32'h0000_0310);
        rd(A_CFG, 32'h0000_0310, "R11 cfg readback");

        // R2 disabled event
        evt_req_en = 4'b0000;
        pulse(4'b0010);
        req_quiet("R2 disabled event no req");
        evt_req_en = 4'b0010;
        pulse(4'b0010);
        @(negedge clk);
        chk("R2 enabled event raises req", {31'b0, dma_req}, 32'd1);

        // R3 / R4 four-transfer burst at 0x10
        for (int k = 0; k < 4; k++)
            dma_xfer(1'b1, 32'hA0 + k, '0, k < 3, "R4 write");
        req_quiet("R3 exactly four requests");
        rd(8'h10, 32'hA0, "R4 offset 0x10");
        rd(8'h14, 32'hA1, "R4 offset 0x14");
        rd(8'h18, 32'hA2, "R4 offset 0x18");
        rd(8'h1C, 32'hA3, "R4 offset 0x1C");

        // R3 single transfer with count 0
        wr(A_CFG, 32'h0000_0040);
        pulse(4'b0010);
        dma_xfer(1'b0, '0, 32'h0, 1'b0, "R3 single read");
        req_quiet("R3 count zero gives one request");

        // R6 event during burst ignored
        wr(A_CFG, 32'h0000_0120);
        pulse(4'b0010);
        pulse(4'b0010);
        dma_xfer(1'b1, 32'hB0, '0, 1'b1, "R6 write");
        pulse(4'b0010);
        dma_xfer(1'b1, 32'hB1, '0, 1'b0, "R6 write");
        req_quiet("R6 no extra burst");
        rd(8'h20, 32'hB0, "R6 first word");
        rd(8'h24, 32'hB1, "R6 second word");
        rd(8'h28, 32'h0, "R6 no third word");

        // R7 restart from start offset
        pulse(4'b0010);
        dma_xfer(1'b0, '0, 32'hB0, 1'b1, "R7 read start");
        dma_xfer(1'b1, 32'hC1, '0, 1'b0, "R7 write");
        rd(8'h24, 32'hC1, "R7 second offset");

        // R8 CPU window accesses
        wr(A_WIN, 32'hD0);
        wr(A_WIN, 32'hD1);
        rd(8'h20, 32'hD1, "R8 cpu window at start");
        rd(8'h24, 32'hC1, "R8 no advance");
        rd(A_WIN, 32'hD1, "R8 cpu window read");

        // R9 out of bank
        wr(A_CFG, 32'h0000_0378);
        pulse(4'b0010);
        dma_xfer(1'b1, 32'hE0, '0, 1'b1, "R9 write");
        dma_xfer(1'b1, 32'hE1, '0, 1'b1, "R9 write");
        dma_xfer(1'b0, '0, 32'h0, 1'b1, "R9 read beyond bank");
        dma_xfer(1'b1, 32'hFFFF_FFFF, '0, 1'b0, "R9 write beyond bank");
        rd(8'h78, 32'hE0, "R9 last-but-one word");
        rd(8'h7C, 32'hE1, "R9 last word");
        rd(A_CFG, 32'h0000_0378, "R9 cfg untouched");

        // R10 counter
        dbg_halt = 1'b1;
        @(negedge clk); c0 = cnt_val;
        @(negedge clk);
        chk("R10 halt without hold counts", {16'b0, cnt_val}, {16'b0, c0 + 16'd1});
        wr(A_CFG, 32'h8000_0378);
        @(negedge clk); c0 = cnt_val;
        @(negedge clk);
        chk("R10 halt with hold freezes", {16'b0, cnt_val}, {16'b0, c0});
        rd(A_CNT, {16'b0, c0}, "R10 counter register frozen");
        @(posedge clk); #1; dbg_halt = 1'b0;
        @(negedge clk); c0 = cnt_val;
        @(negedge clk);
        chk("R10 resumes", {16'b0, cnt_val}, {16'b0, c0 + 16'd1});

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule